// File: doc/BRIEF.md
# Logical Right Shift Execution Unit

This block is the logical right shift slice of an integer execution pipeline. It takes a destination operand, an operand size (byte, half word or word), an 8-bit shift count and the current status flags. It returns the operand shifted right with zeros filling the vacated upper positions, together with an updated flag word. A count from a register byte or from an immediate enters on the same port. An immediate of one is simply the count value 1.

The shift count is reduced to its low five bits before use. Carry receives the last bit that leaves the low end of the operand. Overflow has a defined value only for a single-position shift. Sign, zero and parity follow from the result. Auxiliary carry and the control flags (direction, interrupt enable, trap) are handled as the requirements below state. A request with `in_valid` high is captured on a rising clock edge, and its result appears on the registered outputs one cycle later. The outputs hold their value while no new request arrives.

Flag word layout, used on both `flags_in` and `flags_out`: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 trap, bit 6 interrupt enable, bit 7 direction, bit 8 overflow. Size encoding: 2'b00 byte (8 bits), 2'b01 half word (16 bits), 2'b10 and 2'b11 word (32 bits).

Top module: `rsh_exec_unit`

## Requirements
- R1: For a nonzero effective count c, the result equals the operand, cut to the selected size, shifted right by c with zeros entering at the top. Result bits above the selected size are always 0.
- R2: For a nonzero effective count c, carry (bit 0) equals bit c-1 of the size-cut operand. When c-1 is at or beyond the selected width, carry is 0.
- R3: The effective count is the low 5 bits of `shift_cnt`. Counts of 32 to 255 behave exactly like count mod 32.
- R4: When the effective count is 1, overflow (bit 8) equals the most significant bit of the original operand at the selected size (bit 7, 15 or 31).
- R5: When the effective count is greater than 1, overflow is driven to 0. When the effective count is nonzero, auxiliary carry (bit 2) is driven to 0.
- R6: For a nonzero effective count, sign (bit 4) is the top bit of the result at the selected size. Zero (bit 3) is set when the result at the selected size is all zeros. Parity (bit 1) is set when result bits 7:0 hold an even number of ones.
- R7: When the effective count is 0, the result equals the size-cut operand and all nine flag bits equal `flags_in`.
- R8: For byte and half-word sizes, an effective count at or above the operand width gives a zero result. Carry then follows R2: it is the top operand bit when the count equals the width, and 0 when the count exceeds the width.
- R9: Trap, interrupt enable and direction (bits 5, 6, 7) on `flags_out` always equal those bits of the `flags_in` captured with the request.
- R10: `out_valid` is high for exactly the cycle after a cycle with `in_valid` high. Without `in_valid`, `result` and `flags_out` hold their value. After reset, `out_valid`, `result` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Request strobe; the inputs are captured when it is high |
| operand | input | 32 | Destination operand |
| size_sel | input | 2 | Operand size: 00 byte, 01 half word, 1x word |
| shift_cnt | input | 8 | Raw shift count (register byte or immediate) |
| flags_in | input | 9 | Incoming status flags |
| out_valid | output | 1 | Result and flags valid for the captured request |
| result | output | 32 | Shifted result, zero above the selected size |
| flags_out | output | 9 | Updated status flags |

## Verification
The hardest situations to reach are at the edges of the narrow sizes. One is a byte or half-word shift whose effective count equals, or just exceeds, the operand width, where carry must switch from the top operand bit to 0. The other is a raw count of 32 or more whose low five bits are 0, 1 or a width boundary. Directed requests set these combinations explicitly, using dirty operand bits above the selected size. Random requests with random sizes, counts across the full 8-bit range and random incoming flags then run against a behavioural reference. Idle cycles are placed between requests so that the output hold is checked on every clock.

// File: rtl/rsh_pkg.sv
`timescale 1ns/1ps
package rsh_pkg;

  // Flag word bit positions shared by the unit, its checker and users.
  localparam int FLAG_W  = 9;
  localparam int FL_CARRY = 0;
  localparam int FL_PAR   = 1;
  localparam int FL_AUX   = 2;
  localparam int FL_ZERO  = 3;
  localparam int FL_SIGN  = 4;
  localparam int FL_TRAP  = 5;
  localparam int FL_IEN   = 6;
  localparam int FL_DIR   = 7;
  localparam int FL_OVF   = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } opsize_e;

endpackage

// File: rtl/rsh_rst_sync.sv
`timescale 1ns/1ps
module rsh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rsh_barrel.sv
`timescale 1ns/1ps
// Logarithmic right shifter with zero fill. One guard bit below the
// operand catches the last bit that leaves the low end, which is the carry.
module rsh_barrel #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] data_out,
  output logic              last_out
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] stage [0:SH_W];

  assign stage[0] = {data_in, 1'b0};

  for (genvar gi = 0; gi < SH_W; gi++) begin : g_stage
    localparam int STEP = 1 << gi;
    always_comb begin
      if (shamt[gi]) begin
        stage[gi+1] = {{STEP{1'b0}}, stage[gi][EXT_W-1:STEP]};
      end else begin
        stage[gi+1] = stage[gi];
      end
    end
  end

  assign data_out = stage[SH_W][EXT_W-1:1];
  assign last_out = stage[SH_W][0];

endmodule

// File: rtl/rsh_flag_gen.sv
`timescale 1ns/1ps
// Builds the outgoing flag word from the shifted value, the size-cut
// operand and the effective count.
module rsh_flag_gen
  import rsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] shifted,
  input  logic [DATA_W-1:0] src_cut,
  input  logic              shift_carry,
  input  opsize_e           size,
  input  logic [SH_W-1:0]   shamt,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out
);

  logic res_top;
  logic src_top;
  logic res_zero;
  logic res_par;
  logic cnt_zero;
  logic cnt_one;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        res_top = shifted[7];
        src_top = src_cut[7];
      end
      SZ_HALF: begin
        res_top = shifted[15];
        src_top = src_cut[15];
      end
      default: begin
        res_top = shifted[DATA_W-1];
        src_top = src_cut[DATA_W-1];
      end
    endcase
  end

  // Bits above the selected size are already zero in the shifted value.
  assign res_zero = (shifted == '0);
  assign res_par  = ~(^shifted[7:0]);
  assign cnt_zero = (shamt == '0);
  assign cnt_one  = (shamt == SH_W'(1));

  always_comb begin
    flags_out = flags_in;
    if (!cnt_zero) begin
      flags_out[FL_CARRY] = shift_carry;
      flags_out[FL_PAR]   = res_par;
      flags_out[FL_AUX]   = 1'b0;
      flags_out[FL_ZERO]  = res_zero;
      flags_out[FL_SIGN]  = res_top;
      flags_out[FL_OVF]   = cnt_one ? src_top : 1'b0;
    end
  end

endmodule

// File: rtl/rsh_exec_unit.sv
`timescale 1ns/1ps
module rsh_exec_unit
  import rsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       operand,
  input  logic [1:0]        size_sel,
  input  logic [7:0]        shift_cnt,
  input  logic [8:0]        flags_in,
  output logic              out_valid,
  output logic [31:0]       result,
  output logic [8:0]        flags_out
);

  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] MASK_BYTE = DATA_W'({8{1'b1}});
  localparam logic [DATA_W-1:0] MASK_HALF = DATA_W'({16{1'b1}});

  logic              rst_n_sync;
  opsize_e           size;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] src_cut;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] shifted;
  logic              shift_carry;
  logic [FLAG_W-1:0] flags_new;

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic [FLAG_W-1:0] flags_q, flags_d;

  rsh_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign size  = opsize_e'(size_sel);
  assign shamt = shift_cnt[SH_W-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: size_mask = MASK_BYTE;
      SZ_HALF: size_mask = MASK_HALF;
      default: size_mask = '1;
    endcase
  end

  assign src_cut = operand & size_mask;

  rsh_barrel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_barrel (
    .data_in  (src_cut),
    .shamt    (shamt),
    .data_out (shifted),
    .last_out (shift_carry)
  );

  rsh_flag_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
    .shifted     (shifted),
    .src_cut     (src_cut),
    .shift_carry (shift_carry),
    .size        (size),
    .shamt       (shamt),
    .flags_in    (flags_in),
    .flags_out   (flags_new)
  );

  // Next state: capture on a request, otherwise hold.
  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    flags_d  = flags_q;
    if (in_valid) begin
      result_d = shifted;
      flags_d  = flags_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
      flags_q  <= flags_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign flags_out = flags_q;

endmodule

// File: rtl/rsh_exec_unit_chk.sv
`timescale 1ns/1ps
module rsh_exec_unit_chk
  import rsh_pkg::*;
(
  input logic        clk,
  input logic        rst_n_sync,
  input logic        in_valid,
  input logic [31:0] operand,
  input logic [1:0]  size_sel,
  input logic [7:0]  shift_cnt,
  input logic [8:0]  flags_in,
  input logic        out_valid,
  input logic [31:0] result,
  input logic [8:0]  flags_out
);

  logic        src_msb;
  logic [31:0] src_cut;
  logic [31:0] res_cut;

  always_comb begin
    case (size_sel)
      2'b00: begin
        src_msb = operand[7];
        src_cut = {24'd0, operand[7:0]};
        res_cut = {24'd0, result[7:0]};
      end
      2'b01: begin
        src_msb = operand[15];
        src_cut = {16'd0, operand[15:0]};
        res_cut = {16'd0, result[15:0]};
      end
      default: begin
        src_msb = operand[31];
        src_cut = operand;
        res_cut = result;
      end
    endcase
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |=> out_valid) else $error("valid latency"); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out))) else $error("hold"); // R10

  AST_CTRL_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |=> (flags_out[FL_DIR:FL_TRAP] == $past(flags_in[FL_DIR:FL_TRAP]))) else $error("ctrl flags"); // R9

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && shift_cnt[4:0] == 5'd1) |=> (flags_out[FL_OVF] == $past(src_msb))) else $error("ovf c1"); // R4

  AST_OVF_MULTI: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && shift_cnt[4:0] > 5'd1) |=> !flags_out[FL_OVF]) else $error("ovf multi"); // R5

  AST_AUX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && shift_cnt[4:0] != 5'd0) |=> !flags_out[FL_AUX]) else $error("aux"); // R5

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && shift_cnt[4:0] == 5'd0) |=> (result == $past(src_cut) && flags_out == $past(flags_in))) else $error("count zero"); // R7

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid |-> (result == res_cut || $past(size_sel) != size_sel)) else $error("upper bits"); // R1

endmodule

bind rsh_exec_unit rsh_exec_unit_chk u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .in_valid   (in_valid),
  .operand    (operand),
  .size_sel   (size_sel),
  .shift_cnt  (shift_cnt),
  .flags_in   (flags_in),
  .out_valid  (out_valid),
  .result     (result),
  .flags_out  (flags_out)
);

// File: tb/rsh_exec_unit_tb_top.sv
`timescale 1ns/1ps
module rsh_exec_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] operand;
  logic [1:0]  size_sel;
  logic [7:0]  shift_cnt;
  logic [8:0]  flags_in;
  logic        out_valid;
  logic [31:0] result;
  logic [8:0]  flags_out;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] last_res;
  logic [8:0]  last_flags;
  bit          have_last = 0;

  rsh_exec_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .operand   (operand),
    .size_sel  (size_sel),
    .shift_cnt (shift_cnt),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference and comparison for one request.
  task automatic apply(input logic [31:0] op, input logic [1:0] sz,
                       input logic [7:0] cnt, input logic [8:0] fin, input string tag);
    int          w;
    int          c;
    logic [63:0] m;
    logic [63:0] eres;
    logic [8:0]  ef;
    @(negedge clk);
    if (have_last) begin
      chk({"R10 idle hold result ", tag}, result, last_res);
      chk({"R10 idle hold flags ", tag}, flags_out, last_flags);
      chk({"R10 idle valid low ", tag}, out_valid, 0);
    end
    operand = op; size_sel = sz; shift_cnt = cnt; flags_in = fin; in_valid = 1'b1;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = 64'(op) & ((64'd1 << w) - 64'd1);
    c = int'(cnt) % 32;
    ef = fin;
    if (c == 0) begin
      eres = m;
    end else begin
      eres = m >> c;
      ef[0] = m[c-1];
      ef[1] = ~(^eres[7:0]);
      ef[2] = 1'b0;
      ef[3] = (eres == 64'd0);
      ef[4] = eres[w-1];
      ef[8] = (c == 1) ? m[w-1] : 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R10 valid ", tag}, out_valid, 1);
    chk({"R1 result ", tag}, result, eres);
    chk({"R9 ctrl flags ", tag}, flags_out[7:5], ef[7:5]);
    if (c == 0) begin
      chk({"R7 flags pass ", tag}, flags_out, ef);
    end else begin
      chk({"R2 carry ", tag}, flags_out[0], ef[0]);
      chk({"R6 sign zero parity ", tag}, {flags_out[4], flags_out[3], flags_out[1]},
          {ef[4], ef[3], ef[1]});
      chk({"R5 aux ", tag}, flags_out[2], 0);
      if (c == 1) chk({"R4 overflow ", tag}, flags_out[8], ef[8]);
    end
    last_res = result;
    last_flags = flags_out;
    have_last = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; size_sel = '0; shift_cnt = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", out_valid, 0);
    chk("R10 reset result", result, 0);
    chk("R10 reset flags", flags_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 post-reset valid", out_valid, 0);

    // Directed corner cases.
    apply(32'h8000_0001, 2'b10, 8'd1,   9'h1E0, "R4 word count1");
    apply(32'hFFFF_FF80, 2'b00, 8'd1,   9'h000, "R4 byte count1 dirty upper");
    apply(32'h1234_7F00, 2'b01, 8'd1,   9'h0FF, "R4 half count1 msb0");
    apply(32'hDEAD_BEEF, 2'b10, 8'd0,   9'h1AB, "R7 count0");
    apply(32'hDEAD_BEEF, 2'b00, 8'd32,  9'h155, "R3 R7 count32");
    apply(32'h0000_0003, 2'b10, 8'd33,  9'h000, "R3 count33");
    apply(32'hF000_0000, 2'b10, 8'd255, 9'h0E0, "R3 count255");
    apply(32'hFFFF_FF80, 2'b00, 8'd8,   9'h000, "R8 byte count8");
    apply(32'hFFFF_FF80, 2'b00, 8'd9,   9'h001, "R8 byte count9");
    apply(32'h0000_8000, 2'b01, 8'd16,  9'h000, "R8 half count16");
    apply(32'h0001_FFFF, 2'b01, 8'd17,  9'h1FF, "R8 half count17");
    apply(32'h8000_0000, 2'b11, 8'd31,  9'h000, "R1 word count31");
    apply(32'h0000_0300, 2'b10, 8'd8,   9'h000, "R6 parity even");
    apply(32'h0000_0100, 2'b10, 8'd8,   9'h000, "R6 parity odd");
    apply(32'h0000_00FF, 2'b00, 8'd4,   9'h1E4, "R5 aux clear");

    for (int i = 0; i < 600; i++) begin
      apply($urandom, 2'($urandom), 8'($urandom), 9'($urandom), "R1 random");
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule